// File: doc/BRIEF.md
# Two-Console Byte Link Port

This block is one end of a byte-wide link between two identical handheld consoles. The CPU of each console sees three byte registers on a simple port bus. The first holds the outgoing byte. The second holds the last byte that arrived from the other console. The third combines five software-written control bits with three status bits that only the link hardware sets. A write to the outgoing register on a linked side sends the byte across. The byte lands in the other side's incoming register, both sides record a handshake, and the receiving side gets a non-maskable interrupt after a fixed delay.

Two instances are wired back to back. The strobe, byte and acknowledge outputs of one instance feed the matching inputs of the other, and both share one cable-present signal. A once-per-frame tick lets each side notice a missing cable. That sets an error flag and raises the interrupt. The `PEER_PRIORITY` parameter is set to 1 on one instance and 0 on the other. This fixes how updates that land in the same cycle resolve, so the pair behaves as if the left side's actions were always processed before the right side's.

Top module: `duo_link_port`

## Requirements
- R1: After reset the outgoing register (address 0x03) reads 0x00, the incoming register (0x04) reads 0xFF, the control register (0x05) reads 0x00, `bus_rdata` is 0xFF and `nmi` is low.
- R2: A read drives `bus_rdata` at the clock edge that accepts it. Address 0x03 returns the last byte written to it, whatever the link state. Any address other than 0x03, 0x04 and 0x05 returns 0xFF.
- R3: A write to 0x05 stores bits 7..3 of the data. It zeroes status bits 2..0, and link or frame updates in the same cycle are then applied on top. Software can never set bits 2..0.
- R4: A side is linked only when control bits 5, 4 and 3 are all 1. While a side is unlinked, its status bits do not change and it neither sends, accepts, nor raises a frame interrupt.
- R5: A write to 0x03 on a linked side with the cable present sets its own bit 0 (sent, not yet taken) and offers the byte to the peer. A linked peer stores the byte in its 0x04 register and sets its bit 1 (byte waiting). With the cable absent, or the writer unlinked, nothing is sent and bit 0 stays clear.
- R6: `nmi` rises exactly `DELAY` (default 256) clock cycles after the edge that accepted an incoming byte. A further incoming byte restarts the full delay.
- R7: A read of 0x04 always drops the reader's `nmi`. If the reader is linked and the cable is present, the read also clears the reader's bit 1 and clears bit 0 on a linked peer.
- R8: On `frame_tick`, a linked side with the cable absent sets bit 2 and raises `nmi`. A linked side with the cable present clears bit 2. An unlinked side is unaffected.
- R9: A write to 0x04 has no effect: the incoming register keeps its value.
- R10: When updates collide in one cycle, the side built with `PEER_PRIORITY`=1 lets the peer-caused update win on bits 0 and 1, and the side built with 0 lets its own update win. For `nmi`, delay expiry wins over a 0x04 read, and a 0x04 read wins over a frame raise.
- R11: `nmi` is a level. Once raised, it stays high until a read of 0x04.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cable_ok | input | 1 | Cable present between the two consoles |
| frame_tick | input | 1 | One-cycle frame boundary pulse |
| bus_addr | input | AW | Port address |
| bus_wr | input | 1 | Port write strobe |
| bus_rd | input | 1 | Port read strobe |
| bus_wdata | input | DW | Port write data |
| bus_rdata | output | DW | Registered port read data |
| nmi | output | 1 | Level non-maskable interrupt request |
| lnk_tx_stb | output | 1 | Byte offered to the peer this cycle |
| lnk_tx_byte | output | DW | Byte offered to the peer |
| lnk_ack_stb | output | 1 | This side took its incoming byte |
| lnk_rx_stb | input | 1 | Peer offers a byte this cycle |
| lnk_rx_byte | input | DW | Byte offered by the peer |
| lnk_ack_in | input | 1 | Peer took the byte this side sent |

## Verification
Both the sent flag and the byte-waiting flag can be set by one console and cleared by the other in the same cycle. `nmi` can likewise see a delay expiry, a 0x04 read and a frame raise at one edge. The bench drives both instances of the pair in one cycle. It does so with crossed writes, with a write on one side against a read on the other (in both directions), with a read coinciding with a frame tick, and with a read placed on the exact expiry edge. It then reads the control registers and `nmi` and compares them against the winner that each side's ordering rule predicts.

// File: rtl/duo_link_pkg.sv
package duo_link_pkg;
  localparam int ST_W     = 3;
  localparam int ST_TXP   = 0;
  localparam int ST_RXF   = 1;
  localparam int ST_NOCAB = 2;
  localparam int EN_LSB   = 3;
  localparam int EN_W     = 3;

  typedef enum logic [1:0] {
    SEL_TX   = 2'd0,
    SEL_RX   = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } rd_sel_e;

  typedef struct packed {
    logic    wr_tx;
    logic    wr_ctrl;
    logic    rd_rx;
    logic    rd_en;
    rd_sel_e sel;
  } bus_acc_t;
endpackage

// File: rtl/duo_link_decode.sv
module duo_link_decode
  import duo_link_pkg::*;
#(
  parameter int AW     = 8,
  parameter int A_TX   = 3,
  parameter int A_RX   = 4,
  parameter int A_CTRL = 5
) (
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic          rd,
  output bus_acc_t      acc
);
  logic hit_tx, hit_rx, hit_ctrl;

  assign hit_tx   = (addr == AW'(A_TX));
  assign hit_rx   = (addr == AW'(A_RX));
  assign hit_ctrl = (addr == AW'(A_CTRL));

  always_comb begin
    acc.wr_tx   = wr & hit_tx;
    acc.wr_ctrl = wr & hit_ctrl;
    acc.rd_rx   = rd & hit_rx;
    acc.rd_en   = rd;
    if (hit_tx)        acc.sel = SEL_TX;
    else if (hit_rx)   acc.sel = SEL_RX;
    else if (hit_ctrl) acc.sel = SEL_CTRL;
    else               acc.sel = SEL_NONE;
  end
endmodule

// File: rtl/duo_link_status.sv
module duo_link_status
  import duo_link_pkg::*;
#(
  parameter int DW            = 8,
  parameter bit PEER_PRIORITY = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctrl_wr,
  input  logic [DW-1:0] wdata,
  input  logic          cable_ok,
  input  logic          frame_tick,
  input  logic          own_tx_wr,
  input  logic          own_rx_rd,
  input  logic          peer_tx_stb,
  input  logic          peer_ack_stb,
  output logic [DW-1:0] ctrl_q,
  output logic          link_en
);
  localparam int HI_W = DW - ST_W;

  logic [HI_W-1:0] hi_q;
  logic [ST_W-1:0] lo_q, lo_n, base;
  logic own_set, own_clr, peer_set, peer_clr;
  logic txp_n, rxf_n;

  assign ctrl_q  = {hi_q, lo_q};
  assign link_en = &ctrl_q[EN_LSB +: EN_W];

  assign own_set  = own_tx_wr & link_en & cable_ok;
  assign own_clr  = own_rx_rd & link_en & cable_ok;
  assign peer_set = peer_tx_stb & link_en;
  assign peer_clr = peer_ack_stb & link_en;
  assign base     = ctrl_wr ? '0 : lo_q;

  // Same-cycle ordering of own and peer updates
  if (PEER_PRIORITY) begin : g_peer_wins
    assign txp_n = (base[ST_TXP] | own_set) & ~peer_clr;
    assign rxf_n = (base[ST_RXF] & ~own_clr) | peer_set;
  end else begin : g_own_wins
    assign txp_n = (base[ST_TXP] & ~peer_clr) | own_set;
    assign rxf_n = (base[ST_RXF] | peer_set) & ~own_clr;
  end

  always_comb begin
    lo_n = base;
    lo_n[ST_TXP] = txp_n;
    lo_n[ST_RXF] = rxf_n;
    if (frame_tick && link_en) lo_n[ST_NOCAB] = ~cable_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (ctrl_wr) hi_q <= wdata[DW-1:ST_W];
      lo_q <= lo_n;
    end
  end

  assert_unlinked_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!link_en && !ctrl_wr) |=> $stable(lo_q));

  assert_ctrl_write_R3: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !frame_tick && !peer_tx_stb && !peer_ack_stb && !own_tx_wr && !own_rx_rd)
      |=> (lo_q == '0) && (hi_q == $past(wdata[DW-1:ST_W])));

  assert_sent_flag_R5: assert property (@(posedge clk) disable iff (rst)
    (own_tx_wr && link_en && cable_ok && !peer_ack_stb) |=> lo_q[ST_TXP]);
endmodule

// File: rtl/duo_link_nmi_timer.sv
module duo_link_nmi_timer #(
  parameter int DELAY = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic rd_clr,
  input  logic frame_set,
  output logic nmi
);
  localparam int CW = $clog2(DELAY + 1);

  logic [CW-1:0] cnt_q;
  logic          nmi_q;
  logic          expire;

  assign expire = (cnt_q == CW'(1)) && !load;
  assign nmi    = nmi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      nmi_q <= 1'b0;
    end else begin
      if (load)               cnt_q <= CW'(DELAY);
      else if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
      // frame raise, then read clear, then expiry
      nmi_q <= ((nmi_q | frame_set) & ~rd_clr) | expire;
    end
  end

  assert_cnt_range_R6: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DELAY));

  assert_reload_R6: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == CW'(DELAY)));

  assert_nmi_cause_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(nmi_q) |-> $past(cnt_q == CW'(1) || frame_set));

  assert_read_drops_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && !(cnt_q == CW'(1) && !load)) |=> !nmi_q);

  assert_level_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (nmi_q && !rd_clr) |=> nmi_q);
endmodule

// File: rtl/duo_link_port.sv
module duo_link_port
  import duo_link_pkg::*;
#(
  parameter int          DW            = 8,
  parameter int          AW            = 8,
  parameter int          DELAY         = 256,
  parameter bit          PEER_PRIORITY = 1'b1,
  parameter int          A_TX          = 3,
  parameter int          A_RX          = 4,
  parameter int          A_CTRL        = 5,
  parameter logic [7:0]  TX_INIT       = 8'h00,
  parameter logic [7:0]  RX_INIT       = 8'hFF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cable_ok,
  input  logic          frame_tick,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          nmi,
  output logic          lnk_tx_stb,
  output logic [DW-1:0] lnk_tx_byte,
  output logic          lnk_ack_stb,
  input  logic          lnk_rx_stb,
  input  logic [DW-1:0] lnk_rx_byte,
  input  logic          lnk_ack_in
);
  bus_acc_t      acc;
  logic [DW-1:0] tx_q, rx_q, rdata_q, ctrl_q;
  logic          link_en, rx_accept, frame_set;

  duo_link_decode #(
    .AW(AW), .A_TX(A_TX), .A_RX(A_RX), .A_CTRL(A_CTRL)
  ) u_dec (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd), .acc(acc)
  );

  duo_link_status #(
    .DW(DW), .PEER_PRIORITY(PEER_PRIORITY)
  ) u_stat (
    .clk(clk), .rst(rst),
    .ctrl_wr(acc.wr_ctrl), .wdata(bus_wdata),
    .cable_ok(cable_ok), .frame_tick(frame_tick),
    .own_tx_wr(acc.wr_tx), .own_rx_rd(acc.rd_rx),
    .peer_tx_stb(lnk_rx_stb), .peer_ack_stb(lnk_ack_in),
    .ctrl_q(ctrl_q), .link_en(link_en)
  );

  assign rx_accept = lnk_rx_stb & link_en;
  assign frame_set = frame_tick & link_en & ~cable_ok;

  duo_link_nmi_timer #(.DELAY(DELAY)) u_tmr (
    .clk(clk), .rst(rst),
    .load(rx_accept), .rd_clr(acc.rd_rx), .frame_set(frame_set),
    .nmi(nmi)
  );

  assign lnk_tx_stb  = acc.wr_tx & link_en & cable_ok;
  assign lnk_tx_byte = bus_wdata;
  assign lnk_ack_stb = acc.rd_rx & link_en & cable_ok;
  assign bus_rdata   = rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q    <= DW'(TX_INIT);
      rx_q    <= DW'(RX_INIT);
      rdata_q <= '1;
    end else begin
      if (acc.wr_tx) tx_q <= bus_wdata;
      if (rx_accept) rx_q <= lnk_rx_byte;
      if (acc.rd_en) begin
        unique case (acc.sel)
          SEL_TX:   rdata_q <= tx_q;
          SEL_RX:   rdata_q <= rx_q;
          SEL_CTRL: rdata_q <= ctrl_q;
          default:  rdata_q <= '1;
        endcase
      end
    end
  end

  assert_rx_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !rx_accept |=> $stable(rx_q));
endmodule

// File: tb/duo_link_port_tb_top.sv
module duo_link_port_tb_top;
  localparam int DELAY = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cable = 1'b1;
  always #2 clk = ~clk;

  logic [7:0] l_addr, r_addr, l_wd, r_wd, l_rdata, r_rdata, l_txb, r_txb;
  logic l_wr, l_rd, r_wr, r_rd, l_ft, r_ft, l_nmi, r_nmi;
  logic l_txs, r_txs, l_ack, r_ack;

  duo_link_port #(.DELAY(DELAY), .PEER_PRIORITY(1'b1)) dut_i (
    .clk(clk), .rst(rst), .cable_ok(cable), .frame_tick(l_ft),
    .bus_addr(l_addr), .bus_wr(l_wr), .bus_rd(l_rd), .bus_wdata(l_wd),
    .bus_rdata(l_rdata), .nmi(l_nmi),
    .lnk_tx_stb(l_txs), .lnk_tx_byte(l_txb), .lnk_ack_stb(l_ack),
    .lnk_rx_stb(r_txs), .lnk_rx_byte(r_txb), .lnk_ack_in(r_ack));

  duo_link_port #(.DELAY(DELAY), .PEER_PRIORITY(1'b0)) peer_i (
    .clk(clk), .rst(rst), .cable_ok(cable), .frame_tick(r_ft),
    .bus_addr(r_addr), .bus_wr(r_wr), .bus_rd(r_rd), .bus_wdata(r_wd),
    .bus_rdata(r_rdata), .nmi(r_nmi),
    .lnk_tx_stb(r_txs), .lnk_tx_byte(r_txb), .lnk_ack_stb(r_ack),
    .lnk_rx_stb(l_txs), .lnk_rx_byte(l_txb), .lnk_ack_in(l_ack));

  int total = 0;
  int bad = 0;
  logic [7:0] rv;
  logic [7:0] rx_exp;

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%02h exp=%02h", tag, got, exp);
    end
  endtask

  task automatic idle();
    l_wr = 0; l_rd = 0; r_wr = 0; r_rd = 0; l_ft = 0; r_ft = 0;
    l_addr = 0; r_addr = 0; l_wd = 0; r_wd = 0;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  // side 0 = left, 1 = right; kind 1 = write, 2 = read
  task automatic drv(input int side, input int kind, input logic [7:0] a, input logic [7:0] d);
    if (side == 0) begin
      l_addr = a; l_wd = d; l_wr = (kind == 1); l_rd = (kind == 2);
    end else begin
      r_addr = a; r_wd = d; r_wr = (kind == 1); r_rd = (kind == 2);
    end
  endtask

  task automatic wr(input int side, input logic [7:0] a, input logic [7:0] d);
    drv(side, 1, a, d);
    step();
  endtask

  task automatic rd(input int side, input logic [7:0] a, output logic [7:0] v);
    drv(side, 2, a, 0);
    step();
    v = (side == 0) ? l_rdata : r_rdata;
  endtask

  task automatic ctrl_both(input logic [7:0] lv, input logic [7:0] rvv);
    drv(0, 1, 8'h05, lv);
    drv(1, 1, 8'h05, rvv);
    step();
  endtask

  task automatic drain();
    repeat (DELAY + 4) step();
    rd(0, 8'h04, rv);
    rd(1, 8'h04, rv);
  endtask

  initial begin
    #(200000 * 4);
    total++; bad++;
    $display("FAIL watchdog: got=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle();
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 rdata", l_rdata, 8'hFF);
    chk("R1 nmi", {7'd0, l_nmi | r_nmi}, 8'h00);
    rd(0, 8'h03, rv); chk("R1 tx", rv, 8'h00);
    rd(0, 8'h05, rv); chk("R1 ctrl", rv, 8'h00);
    rd(1, 8'h05, rv); chk("R1 peer ctrl", rv, 8'h00);
    rd(0, 8'h04, rv); chk("R1 rx", rv, 8'hFF);
    rd(0, 8'h00, rv); chk("R2 unmapped", rv, 8'hFF);
    rd(1, 8'h06, rv); chk("R2 unmapped", rv, 8'hFF);

    // R4/R3/R5 sweep over every upper control value on the left
    rx_exp = 8'hFF;
    for (int v = 0; v < 32; v++) begin
      logic en;
      logic [7:0] d;
      en = ((v & 7) == 7);
      d = 8'(v + 8'h40);
      ctrl_both(8'(v << 3), 8'h38);
      wr(0, 8'h03, d);
      if (en) rx_exp = d;
      rd(0, 8'h05, rv); chk("R4 R3 ctrl", rv, 8'((v << 3) | (en ? 1 : 0)));
      rd(0, 8'h03, rv); chk("R2 tx readback", rv, d);
      rd(1, 8'h05, rv); chk("R5 peer flag", rv, 8'h38 | (en ? 8'h02 : 8'h00));
      rd(1, 8'h04, rv); chk("R5 peer rx", rv, rx_exp);
    end
    drain();
    chk("R7 nmi dropped", {7'd0, r_nmi}, 8'h00);

    // R5 cable absent: nothing sent
    cable = 1'b0;
    ctrl_both(8'h38, 8'h38);
    wr(0, 8'h03, 8'h77);
    rd(0, 8'h05, rv); chk("R5 no cable flag", rv, 8'h38);
    rd(1, 8'h04, rv); chk("R5 no cable rx", rv, rx_exp);
    rd(1, 8'h05, rv); chk("R5 no cable peer", rv, 8'h38);
    cable = 1'b1;

    // R6 exact delay, R11 hold, R7 read side effects
    ctrl_both(8'h38, 8'h38);
    wr(0, 8'h03, 8'hA5);
    repeat (DELAY - 1) step();
    chk("R6 before delay", {7'd0, r_nmi}, 8'h00);
    step();
    chk("R6 at delay", {7'd0, r_nmi}, 8'h01);
    repeat (10) step();
    chk("R11 held", {7'd0, r_nmi}, 8'h01);
    rd(0, 8'h05, rv); chk("R5 sent flag", rv, 8'h39);
    rd(1, 8'h05, rv); chk("R5 waiting flag", rv, 8'h3A);
    rd(1, 8'h04, rv); chk("R5 byte", rv, 8'hA5);
    chk("R7 nmi cleared", {7'd0, r_nmi}, 8'h00);
    rd(1, 8'h05, rv); chk("R7 own flag", rv, 8'h38);
    rd(0, 8'h05, rv); chk("R7 peer flag", rv, 8'h38);

    // R6 restart
    wr(0, 8'h03, 8'h3C);
    repeat (100) step();
    wr(0, 8'h03, 8'hC3);
    repeat (DELAY - 1) step();
    chk("R6 restart early", {7'd0, r_nmi}, 8'h00);
    step();
    chk("R6 restart due", {7'd0, r_nmi}, 8'h01);
    rd(1, 8'h04, rv); chk("R6 last byte", rv, 8'hC3);

    // R9 write to incoming register ignored
    wr(1, 8'h04, 8'h11);
    rd(1, 8'h04, rv); chk("R9 rx kept", rv, 8'hC3);

    // R8 frame tick
    cable = 1'b0;
    ctrl_both(8'h38, 8'h30);
    l_ft = 1; r_ft = 1; step();
    chk("R8 nmi linked", {7'd0, l_nmi}, 8'h01);
    chk("R8 nmi unlinked", {7'd0, r_nmi}, 8'h00);
    rd(0, 8'h05, rv); chk("R8 error bit", rv, 8'h3C);
    rd(1, 8'h05, rv); chk("R8 unlinked ctrl", rv, 8'h30);
    cable = 1'b1;
    l_ft = 1; step();
    rd(0, 8'h05, rv); chk("R8 error cleared", rv, 8'h38);
    chk("R11 nmi stays", {7'd0, l_nmi}, 8'h01);
    wr(0, 8'h05, 8'h00);
    rd(0, 8'h04, rv);
    chk("R7 clear unlinked", {7'd0, l_nmi}, 8'h00);

    // R10 crossed writes
    ctrl_both(8'h38, 8'h38);
    drv(0, 1, 8'h03, 8'h12); drv(1, 1, 8'h03, 8'h34); step();
    rd(0, 8'h05, rv); chk("R10 crossed left", rv, 8'h3B);
    rd(1, 8'h05, rv); chk("R10 crossed right", rv, 8'h3B);
    rd(0, 8'h04, rv); chk("R10 crossed left rx", rv, 8'h34);
    rd(1, 8'h04, rv); chk("R10 crossed right rx", rv, 8'h12);

    // R10 left write against right read
    ctrl_both(8'h38, 8'h38);
    drv(0, 1, 8'h03, 8'h56); drv(1, 2, 8'h04, 0); step();
    rd(0, 8'h05, rv); chk("R10 peer clear wins", rv, 8'h38);
    rd(1, 8'h05, rv); chk("R10 own clear wins", rv, 8'h38);
    rd(1, 8'h04, rv); chk("R10 byte landed", rv, 8'h56);

    // R10 right write against left read
    ctrl_both(8'h38, 8'h38);
    drv(1, 1, 8'h03, 8'h78); drv(0, 2, 8'h04, 0); step();
    rd(1, 8'h05, rv); chk("R10 own set wins", rv, 8'h39);
    rd(0, 8'h05, rv); chk("R10 peer set wins", rv, 8'h3A);
    drain();

    // R10 read beats frame raise
    cable = 1'b0;
    wr(0, 8'h05, 8'h38);
    l_ft = 1; drv(0, 2, 8'h04, 0); step();
    chk("R10 read over frame", {7'd0, l_nmi}, 8'h00);
    rd(0, 8'h05, rv); chk("R10 frame error set", rv, 8'h3C);
    cable = 1'b1;

    // R10 expiry beats read
    ctrl_both(8'h38, 8'h38);
    wr(0, 8'h03, 8'h9A);
    repeat (DELAY - 1) step();
    drv(1, 2, 8'h04, 0); step();
    chk("R10 expiry over read", {7'd0, r_nmi}, 8'h01);
    rd(1, 8'h04, rv);
    chk("R7 later read clears", {7'd0, r_nmi}, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule